// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds the byte-wide power-mode register of a small embedded controller and turns its contents into clock-enable and strobe-override outputs. Software writes one byte to the register's address in the special-function space. One bit requests a sleep mode that stops only the processor clock. Another bit requests a deep mode that also stops the oscillator. The remaining bits are a baud-doubling flag and two general-purpose flags. The enables feed clock-gating cells and an oscillator outside this block.

In the sleep mode the processor clock enable drops while the peripheral clock enable (timers, serial port, interrupt logic) stays high, and the address-latch and program-store strobes are forced high. In the deep mode every enable drops, both strobes are forced low, and the register holds its contents. An interrupt request from the interrupt controller wakes the block from the sleep mode only. A reset pin wakes it from either mode, but only once it has been held long enough.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the register reads 0x00, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `strb_ovr`, `ale_lvl` and `psen_lvl` are 0.
- R2: A write with `reg_addr` equal to REG_ADDR (default 0x87) stores bit 7 (baud-double flag), bit 3 and bit 2 (general flags), bit 1 (deep request) and bit 0 (sleep request). Bits 6 to 4 always read 0, and writes to them are ignored. A write to any other address changes nothing.
- R3: When a write sets both bit 1 and bit 0, only bit 1 is stored and bit 0 reads 0, so the deep mode is entered and the sleep mode is not.
- R4: With bit 0 set and bit 1 clear (sleep), `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1, `strb_ovr`=1, `ale_lvl`=1 and `psen_lvl`=1.
- R5: With bit 1 set (deep), `cpu_clk_en`, `per_clk_en` and `osc_en` are 0, `strb_ovr`=1, and `ale_lvl`=`psen_lvl`=0.
- R6: The register updates on the clock edge that samples the write. The enables and strobe levels follow on the next edge, which is the cycle after the write strobe.
- R7: `irq_req` high while bit 0 is set clears bit 0 on that edge, and the outputs return to run values one edge later. In run mode or in the deep mode, `irq_req` changes neither the register nor the outputs.
- R8: When `ext_rst` has been high for more than RST_HOLD consecutive clock cycles (default 24), the whole register clears to 0x00. A shorter pulse changes nothing.
- R9: Bits 7, 3 and 2 have no effect on any enable or strobe output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst | input | 1 | Reset pin level; acts only after RST_HOLD cycles high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Special-function address of the write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Current register contents |
| irq_req | input | 1 | Enabled interrupt request |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Timer, serial and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| strb_ovr | output | 1 | Strobe pins take the forced levels below |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-store strobe level |

## Verification
On every cycle the assertions check that a combined deep-and-sleep write leaves only the deep bit set, that an interrupt clears the sleep bit but never the deep bit, that the reset-hold counter stays within its limit, and that each decoded mode carries its exact set of enable and strobe levels. Other behaviours show up only in the bench scenarios: the one-cycle lag from write to outputs, reserved bits that read 0, writes to other addresses that are ignored, and the difference between a short and a long reset-pin pulse.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PDN  = 2'd2
  } pmode_t;

  localparam int BIT_DBL = 7;
  localparam int BIT_GF1 = 3;
  localparam int BIT_GF0 = 2;
  localparam int BIT_PDN = 1;
  localparam int BIT_SLP = 0;
endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst,
  output logic clr
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !ext_rst) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign clr = ext_rst && (cnt_q == LIMIT);

  // R8
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wake,
  output logic [7:0]        rd_data,
  output pmode_t            mode
);
  logic dbl_q, gf1_q, gf0_q, pdn_q, slp_q;
  logic hit;

  assign hit = wr_en && (wr_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dbl_q <= 1'b0;
      gf1_q <= 1'b0;
      gf0_q <= 1'b0;
      pdn_q <= 1'b0;
      slp_q <= 1'b0;
    end else if (hit) begin
      dbl_q <= wr_data[BIT_DBL];
      gf1_q <= wr_data[BIT_GF1];
      gf0_q <= wr_data[BIT_GF0];
      pdn_q <= wr_data[BIT_PDN];
      slp_q <= wr_data[BIT_SLP] & ~wr_data[BIT_PDN];
    end else if (wake && slp_q) begin
      slp_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data          = 8'h00;
    rd_data[BIT_DBL] = dbl_q;
    rd_data[BIT_GF1] = gf1_q;
    rd_data[BIT_GF0] = gf0_q;
    rd_data[BIT_PDN] = pdn_q;
    rd_data[BIT_SLP] = slp_q;
  end

  always_comb begin
    if (pdn_q)      mode = MODE_PDN;
    else if (slp_q) mode = MODE_IDLE;
    else            mode = MODE_RUN;
  end

  // R3
  pd_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr && wr_data[BIT_PDN] && wr_data[BIT_SLP]) |=> (pdn_q && !slp_q));

  // R7
  irq_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (slp_q && wake && !hit && !clr) |=> !slp_q);

  // R7
  pdn_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (pdn_q && wake && !hit && !clr) |=> (pdn_q && $stable(rd_data)));

  // R3
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(pdn_q && slp_q));
endmodule

// File: rtl/pwr_out_stage.sv
module pwr_out_stage
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  pmode_t mode,
  output logic   cpu_clk_en,
  output logic   per_clk_en,
  output logic   osc_en,
  output logic   strb_ovr,
  output logic   ale_lvl,
  output logic   psen_lvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      strb_ovr   <= 1'b0;
      ale_lvl    <= 1'b0;
      psen_lvl   <= 1'b0;
    end else begin
      cpu_clk_en <= (mode == MODE_RUN);
      per_clk_en <= (mode != MODE_PDN);
      osc_en     <= (mode != MODE_PDN);
      strb_ovr   <= (mode != MODE_RUN);
      ale_lvl    <= (mode == MODE_IDLE);
      psen_lvl   <= (mode == MODE_IDLE);
    end
  end

  // R4
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_ovr && ale_lvl) |-> (!cpu_clk_en && per_clk_en && osc_en && psen_lvl));

  // R5
  pdn_out_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!cpu_clk_en && !per_clk_en && strb_ovr && !ale_lvl && !psen_lvl));

  // R6
  lag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PDN) |=> !osc_en);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h87,
  parameter int RST_HOLD = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              irq_req,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              strb_ovr,
  output logic              ale_lvl,
  output logic              psen_lvl
);
  logic   long_rst;
  pmode_t cur_mode;

  pwr_rst_qual #(.HOLD(RST_HOLD)) rstq_i (
    .clk     (clk),
    .rst     (rst),
    .ext_rst (ext_rst),
    .clr     (long_rst)
  );

  pwr_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) reg_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (long_rst),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .wake    (irq_req),
    .rd_data (reg_rdata),
    .mode    (cur_mode)
  );

  pwr_out_stage out_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (cur_mode),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .strb_ovr   (strb_ovr),
    .ale_lvl    (ale_lvl),
    .psen_lvl   (psen_lvl)
  );
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, ext_rst, reg_wr, irq_req;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic cpu_clk_en, per_clk_en, osc_en, strb_ovr, ale_lvl, psen_lvl;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .strb_ovr(strb_ovr), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl)
  );

  // output bundle: {cpu, per, osc, ovr, ale, psen}
  localparam logic [5:0] O_RUN  = 6'b111000;
  localparam logic [5:0] O_IDLE = 6'b011111;
  localparam logic [5:0] O_PDN  = 6'b000100;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [5:0] outs;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h87, 8'h01, 8'h01, O_IDLE, 4'd4}, // R4 sleep
    '{8'h87, 8'h00, 8'h00, O_RUN,  4'd2}, // R2 back to run
    '{8'h87, 8'h02, 8'h02, O_PDN,  4'd5}, // R5 deep
    '{8'h87, 8'h03, 8'h02, O_PDN,  4'd3}, // R3 both bits
    '{8'h87, 8'hF0, 8'h80, O_RUN,  4'd2}, // R2 reserved ignored
    '{8'h86, 8'hFF, 8'h80, O_RUN,  4'd2}, // R2 other address
    '{8'h87, 8'h8C, 8'h8C, O_RUN,  4'd9}, // R9 flags only
    '{8'h87, 8'h0D, 8'h0D, O_IDLE, 4'd4}, // R4 sleep with flags
    '{8'h87, 8'h00, 8'h00, O_RUN,  4'd2}  // R2 clear
  };

  function automatic logic [5:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, strb_ovr, ale_lvl, psen_lvl};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_irq();
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ext_rst = 1'b0; reg_wr = 1'b0; irq_req = 1'b0;
    reg_addr = 8'h00; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 outs", {2'b00, outs()}, {2'b00, O_RUN});

    // R6: register moves on the write edge, outputs one edge later
    do_write(8'h87, 8'h02);
    check("R6 rdata at write edge", reg_rdata, 8'h02);
    check("R6 outs not yet changed", {2'b00, outs()}, {2'b00, O_RUN});
    @(negedge clk);
    check("R6 outs after lag", {2'b00, outs()}, {2'b00, O_PDN});

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].addr, VECS[i].wdata);
      @(negedge clk);
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), reg_rdata, VECS[i].rdata);
      check($sformatf("R%0d vec%0d outs", VECS[i].req, i), {2'b00, outs()}, {2'b00, VECS[i].outs});
    end

    // R7: interrupt wakes sleep
    do_write(8'h87, 8'h05);
    @(negedge clk);
    pulse_irq();
    check("R7 sleep bit cleared", reg_rdata, 8'h04);
    @(negedge clk);
    check("R7 outs back to run", {2'b00, outs()}, {2'b00, O_RUN});

    // R7: interrupt in run mode has no effect
    do_write(8'h87, 8'h0C);
    @(negedge clk);
    pulse_irq();
    @(negedge clk);
    check("R7 run irq rdata", reg_rdata, 8'h0C);
    check("R7 run irq outs", {2'b00, outs()}, {2'b00, O_RUN});

    // R7: interrupt in deep mode has no effect
    do_write(8'h87, 8'h06);
    @(negedge clk);
    pulse_irq();
    @(negedge clk);
    check("R7 deep irq rdata", reg_rdata, 8'h06);
    check("R7 deep irq outs", {2'b00, outs()}, {2'b00, O_PDN});

    // R8: short reset pin pulse ignored
    ext_rst = 1'b1;
    repeat (20) @(negedge clk);
    ext_rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 short pulse rdata", reg_rdata, 8'h06);
    check("R8 short pulse outs", {2'b00, outs()}, {2'b00, O_PDN});

    // R8: long reset pin pulse clears
    ext_rst = 1'b1;
    repeat (30) @(negedge clk);
    ext_rst = 1'b0;
    @(negedge clk);
    check("R8 long pulse rdata", reg_rdata, 8'h00);
    check("R8 long pulse outs", {2'b00, outs()}, {2'b00, O_RUN});

    // R1: synchronous reset from sleep
    do_write(8'h87, 8'h89);
    @(negedge clk);
    check("R4 before reset", {2'b00, outs()}, {2'b00, O_IDLE});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset from sleep rdata", reg_rdata, 8'h00);
    check("R1 reset from sleep outs", {2'b00, outs()}, {2'b00, O_RUN});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule